// File: doc/BRIEF.md
# Full-map directory coherence controller

This block sits beside a shared memory and keeps, for every memory block it covers, a record of which caches hold a copy and whether one of them may modify it. Caches send it read misses, write misses, upgrades and writebacks. It answers each one. When other caches hold copies it cannot leave alone, it first sends commands to exactly those caches and waits for each of them to acknowledge.

The record for a block is a bit-vector with one flag per cache plus a dirty flag. A set dirty flag means that exactly one flag is set, and that cache holds write permission. Writes use invalidation: the writer ends up as the only flagged cache. A read of a modified block recalls the data from the owner. The owner keeps a clean copy and the reader joins it. A single transaction engine serialises the commanded transactions. Any request that arrives while one is outstanding is told to retry.

Top module: `fullmap_dir`

## Requirements
- R1: After reset, all outputs are idle and every entry is empty (no flags, not dirty). A write to any block is then granted at once with no command.
- R2: A read (kind 0) of a block that is not dirty is answered on the next cycle with a shared grant (code 0) to the requester. The requester's flag is added.
- R3: A read of a block that another cache owns dirty sends recall-keep (command kind 1) to the owner only. After its acknowledgement the read gets a shared grant. The entry then becomes clean with both the owner and the reader flagged.
- R4: A write (kind 1) or upgrade (kind 2) finds other flagged caches. It sends one command whose target mask holds exactly those caches, never the requester. The command is an invalidate (kind 0) for a clean block or a recall-drop (kind 2) for a dirty one.
- R5: A commanded transaction completes only when every targeted cache has acknowledged. Acks from caches that were not targeted are ignored. The response comes on the cycle after the last acknowledgement. A write transaction answers with an exclusive grant (code 1) and leaves only the requester flagged with the dirty flag set.
- R6: A write or upgrade that finds no other flagged cache is granted exclusive on the next cycle. No command is sent.
- R7: While a commanded transaction is outstanding, every request gets a retry pulse addressed to its sender on the next cycle. Such a request changes nothing.
- R8: A writeback (kind 3) from the dirty owner clears both the dirty flag and its presence flag. It is answered with code 2.
- R9: A writeback from a cache that is not the dirty owner is answered with code 2 and leaves the entry unchanged.
- R10: Whenever an entry is dirty, exactly one of its presence flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 upgrade, 3 writeback |
| req_src | input | CID_W | Requesting cache |
| req_addr | input | ADDR_W | Block index |
| ack | input | NUM_CACHES | Per-cache acknowledgement pulses |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 2 | 0 shared grant, 1 exclusive grant, 2 writeback done |
| rsp_dst | output | CID_W | Cache receiving the response |
| rsp_addr | output | ADDR_W | Block of the response |
| cmd_valid | output | 1 | Command pulse |
| cmd_kind | output | 2 | 0 invalidate, 1 recall-keep, 2 recall-drop |
| cmd_mask | output | NUM_CACHES | Caches addressed by the command |
| cmd_addr | output | ADDR_W | Block of the command |
| nack_valid | output | 1 | Retry pulse |
| nack_dst | output | CID_W | Cache told to retry |

## Verification
Every response to a request that needs no command, every command and every retry pulse is registered. Each one appears on the cycle after the clock edge that sampled the request. A commanded transaction responds on the cycle after the edge that sampled its last acknowledgement. The bench drives requests and acks on falling edges and holds them for one cycle. It reads the outputs at the next falling edge, which is the one cycle at which the pulse is visible. While acks are still outstanding it checks that no response has appeared. Hidden entry state is inferred from the mask and kind of the next command that the block sends for the same block.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    REQ_READ    = 2'd0,
    REQ_WRITE   = 2'd1,
    REQ_UPGRADE = 2'd2,
    REQ_WBACK   = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    RSP_SHARED = 2'd0,
    RSP_EXCL   = 2'd1,
    RSP_WBDONE = 2'd2,
    RSP_NONE   = 2'd3
  } rsp_code_e;

  typedef enum logic [1:0] {
    CMD_INVAL       = 2'd0,
    CMD_RECALL_KEEP = 2'd1,
    CMD_RECALL_DROP = 2'd2,
    CMD_NONE        = 2'd3
  } cmd_kind_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/dir_entry_store.sv
module dir_entry_store #(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 8,
  localparam int ADDR_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [NUM_CACHES-1:0] rd_presence,
  output logic                  rd_dirty,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [NUM_CACHES-1:0] wr_presence,
  input  logic                  wr_dirty
);
  logic [NUM_CACHES-1:0] pres_q  [NUM_BLOCKS];
  logic                  dirty_q [NUM_BLOCKS];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
      end else if (hit) begin
        pres_q[b]  <= wr_presence;
        dirty_q[b] <= wr_dirty;
      end
    end
  end

  assign rd_presence = pres_q[rd_addr];
  assign rd_dirty    = dirty_q[rd_addr];

  // R10
  dirty_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dirty |-> ($countones(rd_presence) == 1));
endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dir_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  localparam int CID_W = $clog2(NUM_CACHES)
) (
  input  req_kind_e             kind,
  input  logic [CID_W-1:0]      src,
  input  logic [NUM_CACHES-1:0] ent_presence,
  input  logic                  ent_dirty,
  output logic                  go_wait,
  output rsp_code_e             code,
  output logic                  wr_en,
  output logic [NUM_CACHES-1:0] wr_presence,
  output logic                  wr_dirty,
  output cmd_kind_e             cmd_kind,
  output logic [NUM_CACHES-1:0] cmd_mask
);
  logic [NUM_CACHES-1:0] src_bit;
  logic [NUM_CACHES-1:0] others;

  assign src_bit = NUM_CACHES'(1) << src;
  assign others  = ent_presence & ~src_bit;

  always_comb begin
    go_wait     = 1'b0;
    code        = RSP_NONE;
    wr_en       = 1'b0;
    wr_presence = ent_presence;
    wr_dirty    = ent_dirty;
    cmd_kind    = CMD_NONE;
    cmd_mask    = others;
    unique case (kind)
      REQ_READ: begin
        if (ent_dirty && (others != '0)) begin
          go_wait  = 1'b1;
          cmd_kind = CMD_RECALL_KEEP;
        end else if (ent_dirty) begin
          code = RSP_EXCL;
        end else begin
          code        = RSP_SHARED;
          wr_en       = 1'b1;
          wr_presence = ent_presence | src_bit;
          wr_dirty    = 1'b0;
        end
      end
      REQ_WRITE, REQ_UPGRADE: begin
        if (others != '0) begin
          go_wait  = 1'b1;
          cmd_kind = ent_dirty ? CMD_RECALL_DROP : CMD_INVAL;
        end else begin
          code        = RSP_EXCL;
          wr_en       = 1'b1;
          wr_presence = src_bit;
          wr_dirty    = 1'b1;
        end
      end
      REQ_WBACK: begin
        code = RSP_WBDONE;
        if (ent_dirty && (ent_presence == src_bit)) begin
          wr_en       = 1'b1;
          wr_presence = '0;
          wr_dirty    = 1'b0;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_ack_collect.sv
module dir_ack_collect #(
  parameter int NUM_CACHES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NUM_CACHES-1:0] load_mask,
  input  logic [NUM_CACHES-1:0] ack,
  output logic                  done
);
  logic [NUM_CACHES-1:0] pending_q;
  logic [NUM_CACHES-1:0] pending_d;

  always_comb begin
    if (load) pending_d = load_mask;
    else      pending_d = pending_q & ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= '0;
    else        pending_q <= pending_d;
  end

  assign done = (pending_q != '0) && ((pending_q & ~ack) == '0);

  // R5
  pending_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((pending_q & ~$past(pending_q)) == '0));
endmodule

// File: rtl/fullmap_dir.sv
module fullmap_dir
  import dir_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int NUM_BLOCKS = 8,
  localparam int CID_W  = $clog2(NUM_CACHES),
  localparam int ADDR_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [1:0]            req_kind,
  input  logic [CID_W-1:0]      req_src,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [NUM_CACHES-1:0] ack,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_code,
  output logic [CID_W-1:0]      rsp_dst,
  output logic [ADDR_W-1:0]     rsp_addr,
  output logic                  cmd_valid,
  output logic [1:0]            cmd_kind,
  output logic [NUM_CACHES-1:0] cmd_mask,
  output logic [ADDR_W-1:0]     cmd_addr,
  output logic                  nack_valid,
  output logic [CID_W-1:0]      nack_dst
);
  ctrl_state_e           state_q, state_d;
  logic [CID_W-1:0]      txn_src_q;
  logic [ADDR_W-1:0]     txn_addr_q;
  logic                  txn_read_q;
  logic                  txn_en;
  logic [NUM_CACHES-1:0] txn_bit;

  logic [ADDR_W-1:0]     st_rd_addr;
  logic [NUM_CACHES-1:0] ent_pres;
  logic                  ent_dirty;
  logic                  st_wr_en, st_wr_dirty;
  logic [ADDR_W-1:0]     st_wr_addr;
  logic [NUM_CACHES-1:0] st_wr_pres;

  logic                  dec_wait, dec_wr_en, dec_dirty;
  rsp_code_e             dec_code;
  logic [NUM_CACHES-1:0] dec_pres, dec_mask;
  cmd_kind_e             dec_cmd;

  logic                  load, done;

  logic                  rsp_valid_d, cmd_valid_d, nack_valid_d;
  rsp_code_e             rsp_code_d, rsp_code_q;
  logic [CID_W-1:0]      rsp_dst_d;
  logic [ADDR_W-1:0]     rsp_addr_d;
  cmd_kind_e             cmd_kind_q;

  assign st_rd_addr = (state_q == ST_WAIT) ? txn_addr_q : req_addr;
  assign txn_bit    = NUM_CACHES'(1) << txn_src_q;

  dir_entry_store #(.NUM_CACHES(NUM_CACHES), .NUM_BLOCKS(NUM_BLOCKS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(st_rd_addr), .rd_presence(ent_pres), .rd_dirty(ent_dirty),
    .wr_en(st_wr_en), .wr_addr(st_wr_addr),
    .wr_presence(st_wr_pres), .wr_dirty(st_wr_dirty)
  );

  dir_decide #(.NUM_CACHES(NUM_CACHES)) u_decide (
    .kind(req_kind_e'(req_kind)), .src(req_src),
    .ent_presence(ent_pres), .ent_dirty(ent_dirty),
    .go_wait(dec_wait), .code(dec_code), .wr_en(dec_wr_en),
    .wr_presence(dec_pres), .wr_dirty(dec_dirty),
    .cmd_kind(dec_cmd), .cmd_mask(dec_mask)
  );

  dir_ack_collect #(.NUM_CACHES(NUM_CACHES)) u_acks (
    .clk(clk), .rst_n(rst_n),
    .load(load), .load_mask(dec_mask), .ack(ack), .done(done)
  );

  always_comb begin
    state_d      = state_q;
    load         = 1'b0;
    txn_en       = 1'b0;
    st_wr_en     = 1'b0;
    st_wr_addr   = req_addr;
    st_wr_pres   = dec_pres;
    st_wr_dirty  = dec_dirty;
    rsp_valid_d  = 1'b0;
    rsp_code_d   = dec_code;
    rsp_dst_d    = req_src;
    rsp_addr_d   = req_addr;
    cmd_valid_d  = 1'b0;
    nack_valid_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (dec_wait) begin
            cmd_valid_d = 1'b1;
            load        = 1'b1;
            txn_en      = 1'b1;
            state_d     = ST_WAIT;
          end else begin
            rsp_valid_d = 1'b1;
            st_wr_en    = dec_wr_en;
          end
        end
      end
      ST_WAIT: begin
        nack_valid_d = req_valid;
        if (done) begin
          state_d     = ST_IDLE;
          st_wr_en    = 1'b1;
          st_wr_addr  = txn_addr_q;
          st_wr_pres  = txn_read_q ? (ent_pres | txn_bit) : txn_bit;
          st_wr_dirty = !txn_read_q;
          rsp_valid_d = 1'b1;
          rsp_code_d  = txn_read_q ? RSP_SHARED : RSP_EXCL;
          rsp_dst_d   = txn_src_q;
          rsp_addr_d  = txn_addr_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      rsp_valid  <= 1'b0;
      cmd_valid  <= 1'b0;
      nack_valid <= 1'b0;
    end else begin
      state_q    <= state_d;
      rsp_valid  <= rsp_valid_d;
      cmd_valid  <= cmd_valid_d;
      nack_valid <= nack_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_src_q  <= '0;
      txn_addr_q <= '0;
      txn_read_q <= 1'b0;
      rsp_code_q <= RSP_NONE;
      rsp_dst    <= '0;
      rsp_addr   <= '0;
      cmd_kind_q <= CMD_NONE;
      cmd_mask   <= '0;
      cmd_addr   <= '0;
      nack_dst   <= '0;
    end else begin
      if (txn_en) begin
        txn_src_q  <= req_src;
        txn_addr_q <= req_addr;
        txn_read_q <= (req_kind == REQ_READ);
        cmd_kind_q <= dec_cmd;
        cmd_mask   <= dec_mask;
        cmd_addr   <= req_addr;
      end
      if (rsp_valid_d) begin
        rsp_code_q <= rsp_code_d;
        rsp_dst    <= rsp_dst_d;
        rsp_addr   <= rsp_addr_d;
      end
      if (nack_valid_d) nack_dst <= req_src;
    end
  end

  assign rsp_code = rsp_code_q;
  assign cmd_kind = cmd_kind_q;

  // R7
  retry_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && req_valid) |=> (nack_valid && nack_dst == $past(req_src)));

  // R4
  cmd_skips_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!cmd_mask[txn_src_q] && cmd_mask != '0));

  // R5
  no_rsp_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !rsp_valid);

  // R6
  cmd_rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !rsp_valid);
endmodule

// File: tb/tb_fullmap_dir.sv
module tb_fullmap_dir;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [1:0] req_src = 2'd0;
  logic [2:0] req_addr = 3'd0;
  logic [3:0] ack = 4'd0;
  logic       rsp_valid, cmd_valid, nack_valid;
  logic [1:0] rsp_code, rsp_dst, cmd_kind, nack_dst;
  logic [2:0] rsp_addr, cmd_addr;
  logic [3:0] cmd_mask;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fullmap_dir #(.NUM_CACHES(NC), .NUM_BLOCKS(NB)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_src(req_src), .req_addr(req_addr),
    .ack(ack),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_dst(rsp_dst), .rsp_addr(rsp_addr),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_mask(cmd_mask), .cmd_addr(cmd_addr),
    .nack_valid(nack_valid), .nack_dst(nack_dst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] kind, input logic [1:0] src, input logic [2:0] addr);
    req_valid = 1'b1; req_kind = kind; req_src = src; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic give_ack(input logic [3:0] m);
    ack = m;
    @(negedge clk);
    ack = 4'd0;
  endtask

  task automatic exp_rsp(input string tag, input logic [1:0] code, input logic [1:0] dst,
                         input logic [2:0] addr);
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " rsp_code"}, 32'(rsp_code), 32'(code));
    chk({tag, " rsp_dst"}, 32'(rsp_dst), 32'(dst));
    chk({tag, " rsp_addr"}, 32'(rsp_addr), 32'(addr));
    chk({tag, " no cmd"}, 32'(cmd_valid), 32'd0);
  endtask

  task automatic exp_cmd(input string tag, input logic [1:0] kind, input logic [3:0] mask,
                         input logic [2:0] addr);
    chk({tag, " cmd_valid"}, 32'(cmd_valid), 32'd1);
    chk({tag, " cmd_kind"}, 32'(cmd_kind), 32'(kind));
    chk({tag, " cmd_mask"}, 32'(cmd_mask), 32'(mask));
    chk({tag, " cmd_addr"}, 32'(cmd_addr), 32'(addr));
    chk({tag, " no rsp"}, 32'(rsp_valid), 32'd0);
  endtask

  task automatic exp_quiet(input string tag);
    chk({tag, " rsp idle"}, 32'(rsp_valid), 32'd0);
    chk({tag, " cmd idle"}, 32'(cmd_valid), 32'd0);
  endtask

  task automatic t_reset;
    exp_quiet("R1 reset");
    chk("R1 reset nack", 32'(nack_valid), 32'd0);
    send(2'd1, 2'd0, 3'd4);
    exp_rsp("R1 empty entry write", 2'd1, 2'd0, 3'd4);
  endtask

  task automatic t_read_clean;
    send(2'd0, 2'd0, 3'd1);
    exp_rsp("R2 read c0", 2'd0, 2'd0, 3'd1);
    send(2'd0, 2'd2, 3'd1);
    exp_rsp("R2 read c2", 2'd0, 2'd2, 3'd1);
  endtask

  task automatic t_write_inval;
    send(2'd1, 2'd1, 3'd1);
    exp_cmd("R4 write inval", 2'd0, 4'b0101, 3'd1);
    send(2'd0, 2'd3, 3'd6);
    chk("R7 nack valid", 32'(nack_valid), 32'd1);
    chk("R7 nack dst", 32'(nack_dst), 32'd3);
    exp_quiet("R7 during wait");
    give_ack(4'b0001);
    exp_quiet("R5 partial ack");
    give_ack(4'b1000);
    exp_quiet("R5 stray ack ignored");
    give_ack(4'b0100);
    exp_rsp("R5 last ack grant", 2'd1, 2'd1, 3'd1);
    chk("R7 nack gone", 32'(nack_valid), 32'd0);
  endtask

  task automatic t_read_dirty;
    send(2'd0, 2'd3, 3'd1);
    exp_cmd("R3 recall keep", 2'd1, 4'b0010, 3'd1);
    give_ack(4'b0010);
    exp_rsp("R3 shared after recall", 2'd0, 2'd3, 3'd1);
    send(2'd1, 2'd0, 3'd1);
    exp_cmd("R3 both flagged clean", 2'd0, 4'b1010, 3'd1);
    give_ack(4'b1010);
    exp_rsp("R5 joint ack grant", 2'd1, 2'd0, 3'd1);
  endtask

  task automatic t_write_dirty;
    send(2'd1, 2'd2, 3'd1);
    exp_cmd("R4 recall drop", 2'd2, 4'b0001, 3'd1);
    give_ack(4'b0001);
    exp_rsp("R5 grant after drop", 2'd1, 2'd2, 3'd1);
  endtask

  task automatic t_writeback;
    send(2'd3, 2'd0, 3'd1);
    exp_rsp("R9 stale wb", 2'd2, 2'd0, 3'd1);
    send(2'd0, 2'd1, 3'd1);
    exp_cmd("R9 owner kept", 2'd1, 4'b0100, 3'd1);
    give_ack(4'b0100);
    exp_rsp("R3 read after wb", 2'd0, 2'd1, 3'd1);
    send(2'd3, 2'd2, 3'd1);
    exp_rsp("R9 wb of clean", 2'd2, 2'd2, 3'd1);
    send(2'd1, 2'd3, 3'd1);
    exp_cmd("R9 flags kept", 2'd0, 4'b0110, 3'd1);
    give_ack(4'b0110);
    exp_rsp("R5 grant c3", 2'd1, 2'd3, 3'd1);
    send(2'd3, 2'd0, 3'd4);
    exp_rsp("R8 owner wb", 2'd2, 2'd0, 3'd4);
    send(2'd1, 2'd1, 3'd4);
    exp_rsp("R8 entry cleared", 2'd1, 2'd1, 3'd4);
  endtask

  task automatic t_upgrade;
    send(2'd0, 2'd0, 3'd5);
    exp_rsp("R2 read blk5 c0", 2'd0, 2'd0, 3'd5);
    send(2'd0, 2'd1, 3'd5);
    exp_rsp("R2 read blk5 c1", 2'd0, 2'd1, 3'd5);
    send(2'd2, 2'd1, 3'd5);
    exp_cmd("R4 upgrade inval", 2'd0, 4'b0001, 3'd5);
    give_ack(4'b0001);
    exp_rsp("R5 upgrade grant", 2'd1, 2'd1, 3'd5);
    send(2'd2, 2'd1, 3'd5);
    exp_rsp("R6 owner upgrade", 2'd1, 2'd1, 3'd5);
    send(2'd1, 2'd2, 3'd7);
    exp_rsp("R6 fresh write", 2'd1, 2'd2, 3'd7);
    send(2'd0, 2'd3, 3'd2);
    exp_rsp("R2 untouched block", 2'd0, 2'd3, 3'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_clean();
    t_write_inval();
    t_read_dirty();
    t_write_dirty();
    t_writeback();
    t_upgrade();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule